// File: doc/BRIEF.md
# Break and Synch Field Baud Detector

This block is the receive-side front end of an auto-baud serial link. It watches the receive line for a long low break field. Between the break and the synch character it expects a high delimiter of 1 to 4 bit times. The synch character is 0x55. The block times the synch character in system clock cycles and hands a new bit period, in clocks, to the receiver's baud generator. It flags recognised breaks. It reports a break that runs too long and a synch field that the measurement counter cannot span. It also raises a receive-ready pulse under the rules of the dormant and break-report settings.

A companion emitter sends a break on request. In auto-baud mode it sends the break, the delimiter and a synch character. In any other mode it sends the break and the delimiter only. Both sides use the currently measured bit period, so a unit that has learned the rate from one frame sends its own frames at that rate.

Top module: `brk_sync_detect`

## Requirements
- R1: Reset loads `period_out` from `base_period`, holds `txd` high and `tx_busy` low, and leaves every pulse output low.
- R2: A low stretch on `rxd` of at least 11 bit times at the current period, ended by a rise, gives one `brk_seen` pulse. A shorter stretch gives none.
- R3: With `detect_en` high, a low stretch longer than 22 bit times gives one `brk_timeout` pulse and no `brk_seen`. Exactly 22 bit times is still a valid break.
- R4: After a break in auto-baud mode, the high delimiter must last at least (`delim_sel`+1) bit times, so codes 0..3 mean 1..4 bits. A shorter delimiter abandons the frame and nothing is measured.
- R5: Let T be the number of clocks from the first to the fifth falling edge of the synch character. A valid frame gives one `sync_done` pulse and sets `period_out` to floor(T/8).
- R6: If the fifth falling edge has not arrived within 2^CW-1 clocks of the first one, `sync_timeout` pulses and `period_out` is kept.
- R7: With `detect_en` low, breaks are still flagged. No timeout or `sync_done` pulse occurs, and `period_out` never changes.
- R8: `rx_ready` pulses with every `sync_done`, even when `dormant` is high. It pulses with a `brk_seen` only when `brk_report_en` is 1 and `dormant` is 0.
- R9: A `tx_wr` while `tx_brk_req` is 1, with `detect_en` high and `tx_data` equal to 0x55, emits the following on `txd`, each bit lasting one current bit period:
  - 13 low bits;
  - (`delim_sel`+1) high bits;
  - a low start bit;
  - the eight data bits, LSB first;
  - a high stop bit.
- R10: A break request with `detect_en` low, or with any data other than 0x55, emits only the 13 low bits and the delimiter. A `tx_wr` without `tx_brk_req`, or any write while busy, is ignored.
- R11: `tx_busy` is high for exactly the cycles of an emission, and `txd` is high whenever `tx_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Receive line, idle high |
| detect_en | input | 1 | Auto-baud mode: measure the synch field and arm the timeouts |
| delim_sel | input | 2 | Minimum delimiter length, code+1 bit times |
| dormant | input | 1 | Sleep mode: only break plus synch raises ready |
| brk_report_en | input | 1 | Let a received break raise ready |
| base_period | input | CW-3 | Bit period in clocks loaded at reset |
| tx_brk_req | input | 1 | Next write sends a break |
| tx_wr | input | 1 | Write strobe for the emitter |
| tx_data | input | 8 | Character written with the strobe |
| period_out | output | CW-3 | Current bit period in clocks |
| brk_seen | output | 1 | Break recognised (pulse) |
| brk_timeout | output | 1 | Break too long (pulse) |
| sync_timeout | output | 1 | Synch field overflowed the counter (pulse) |
| sync_done | output | 1 | Valid break plus synch measured (pulse) |
| rx_ready | output | 1 | Receive-ready pulse |
| txd | output | 1 | Transmit line |
| tx_busy | output | 1 | Emission in progress |

## Verification
A wrong break or delimiter count shows at the ports as a missing or extra `brk_seen` or `sync_done` pulse. This appears a few cycles after the line rises or falls, and the sweeps place the low and high lengths one cycle either side of each threshold. A fault in the synch measurement changes `period_out` once the fifth falling edge has passed. From then on it also moves the break thresholds and the emitter's bit timing for every later frame. The emitter is compared cycle by cycle against the expected bit sequence. In loopback its own output must measure back to the same period.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam logic [7:0] SYNCH_CHAR   = 8'h55;
  localparam int         BRK_MIN_BITS = 11;
  localparam int         BRK_MAX_BITS = 22;
  localparam int         SYNCH_FALLS  = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_LOW,
    RX_WAIT_HI,
    RX_DELIM,
    RX_MEAS
  } rx_state_e;

  // Bit i of an emitted break frame: low break, high delimiter, then an
  // optional start/data/stop character sent LSB first.
  function automatic logic frame_bit(int i, int brk_bits, int dl, logic [7:0] d);
    int j;
    logic [7:0] sh;
    j = i - brk_bits - dl;
    sh = d >> ((j > 0) ? (j - 1) : 0);
    if (i < brk_bits)  return 1'b0;
    else if (j < 0)    return 1'b1;
    else if (j == 0)   return 1'b0;
    else if (j <= 8)   return sh[0];
    else               return 1'b1;
  endfunction
endpackage

// File: rtl/bsd_rx_edge.sv
module bsd_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic fall,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], rxd};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
  assign rise = ~pipe[STAGES] & pipe[STAGES-1];
endmodule

// File: rtl/bsd_rx_fsm.sv
module bsd_rx_fsm
  import bsd_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = CW - 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          rise,
  input  logic          detect_en,
  input  logic [1:0]    delim_sel,
  input  logic          dormant,
  input  logic          brk_report_en,
  input  logic [PW-1:0] base_period,
  output logic [PW-1:0] period_q,
  output logic          brk_seen,
  output logic          brk_to,
  output logic          syn_to,
  output logic          syn_done,
  output logic          ready
);
  localparam int BW = PW + 5;

  rx_state_e     st;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] scnt;
  logic [2:0]    nfall;
  logic [BW-1:0] per_x, brk_min, brk_max, delim_min;
  logic [PW-1:0] meas;

  assign per_x     = BW'(period_q);
  assign brk_min   = per_x * BW'(BRK_MIN_BITS);
  assign brk_max   = per_x * BW'(BRK_MAX_BITS);
  assign delim_min = per_x * (BW'(delim_sel) + BW'(1));
  assign meas      = PW'(scnt >> 3);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      bcnt     <= '0;
      scnt     <= '0;
      nfall    <= '0;
      period_q <= base_period;
      brk_seen <= 1'b0;
      brk_to   <= 1'b0;
      syn_to   <= 1'b0;
      syn_done <= 1'b0;
      ready    <= 1'b0;
    end else begin
      brk_seen <= 1'b0;
      brk_to   <= 1'b0;
      syn_to   <= 1'b0;
      syn_done <= 1'b0;
      ready    <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (fall) begin
            st   <= RX_LOW;
            bcnt <= BW'(1);
          end
        end
        RX_LOW: begin
          if (rise) begin
            if (bcnt >= brk_min) begin
              brk_seen <= 1'b1;
              ready    <= brk_report_en & ~dormant;
              st       <= detect_en ? RX_DELIM : RX_IDLE;
              bcnt     <= BW'(1);
            end else begin
              st <= RX_IDLE;
            end
          end else if (detect_en && bcnt >= brk_max) begin
            brk_to <= 1'b1;
            st     <= RX_WAIT_HI;
          end else if (bcnt != '1) begin
            bcnt <= bcnt + BW'(1);
          end
        end
        RX_WAIT_HI: begin
          if (rise) st <= RX_IDLE;
        end
        RX_DELIM: begin
          if (!detect_en) begin
            st <= RX_IDLE;
          end else if (fall) begin
            if (bcnt >= delim_min) begin
              st    <= RX_MEAS;
              scnt  <= CW'(1);
              nfall <= 3'd1;
            end else begin
              st   <= RX_LOW;
              bcnt <= BW'(1);
            end
          end else if (bcnt != '1) begin
            bcnt <= bcnt + BW'(1);
          end
        end
        RX_MEAS: begin
          if (!detect_en) begin
            st <= RX_IDLE;
          end else if (fall && nfall == 3'(SYNCH_FALLS - 1)) begin
            period_q <= (meas == '0) ? PW'(1) : meas;
            syn_done <= 1'b1;
            ready    <= 1'b1;
            st       <= RX_IDLE;
          end else if (scnt == '1) begin
            syn_to <= 1'b1;
            st     <= RX_IDLE;
          end else begin
            scnt <= scnt + CW'(1);
            if (fall) nfall <= nfall + 3'd1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsd_tx_gen.sv
module bsd_tx_gen
  import bsd_pkg::*;
#(
  parameter int PW       = 13,
  parameter int BRK_BITS = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period,
  input  logic          detect_en,
  input  logic [1:0]    delim_sel,
  input  logic          brk_req,
  input  logic          wr,
  input  logic [7:0]    data,
  output logic          txd,
  output logic          busy
);
  localparam int SW = BRK_BITS + 4 + 10;
  localparam int NW = $clog2(SW + 1);

  logic [SW-1:0] frame, shreg;
  logic [NW-1:0] len, nleft;
  logic [PW-1:0] pcnt, per_l;
  logic          with_syn, start;

  assign with_syn = detect_en && (data == SYNCH_CHAR);
  assign start    = wr & brk_req & ~busy;
  assign len      = NW'(BRK_BITS) + NW'(delim_sel) + NW'(1) + (with_syn ? NW'(10) : NW'(0));

  always_comb begin
    for (int i = 0; i < SW; i++) begin
      frame[i] = frame_bit(i, BRK_BITS, int'(delim_sel) + 1, data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd   <= 1'b1;
      busy  <= 1'b0;
      shreg <= '1;
      nleft <= '0;
      pcnt  <= '0;
      per_l <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      txd   <= frame[0];
      shreg <= frame >> 1;
      nleft <= len - NW'(1);
      pcnt  <= PW'(1);
      per_l <= period;
    end else if (busy) begin
      if (pcnt >= per_l) begin
        pcnt <= PW'(1);
        if (nleft == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd   <= shreg[0];
          shreg <= shreg >> 1;
          nleft <= nleft - NW'(1);
        end
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/brk_sync_detect.sv
module brk_sync_detect #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TX_BRK_BITS = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd,
  input  logic          detect_en,
  input  logic [1:0]    delim_sel,
  input  logic          dormant,
  input  logic          brk_report_en,
  input  logic [CW-4:0] base_period,
  input  logic          tx_brk_req,
  input  logic          tx_wr,
  input  logic [7:0]    tx_data,
  output logic [CW-4:0] period_out,
  output logic          brk_seen,
  output logic          brk_timeout,
  output logic          sync_timeout,
  output logic          sync_done,
  output logic          rx_ready,
  output logic          txd,
  output logic          tx_busy
);
  localparam int PW = CW - 3;

  logic fall, rise;

  bsd_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .rxd(rxd), .fall(fall), .rise(rise)
  );

  bsd_rx_fsm #(.CW(CW), .PW(PW)) u_rx (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .detect_en(detect_en), .delim_sel(delim_sel), .dormant(dormant),
    .brk_report_en(brk_report_en), .base_period(base_period),
    .period_q(period_out), .brk_seen(brk_seen), .brk_to(brk_timeout),
    .syn_to(sync_timeout), .syn_done(sync_done), .ready(rx_ready)
  );

  bsd_tx_gen #(.PW(PW), .BRK_BITS(TX_BRK_BITS)) u_tx (
    .clk(clk), .rst(rst), .period(period_out), .detect_en(detect_en),
    .delim_sel(delim_sel), .brk_req(tx_brk_req), .wr(tx_wr),
    .data(tx_data), .txd(txd), .busy(tx_busy)
  );
endmodule

// File: rtl/brk_sync_detect_sva.sv
module brk_sync_detect_sva #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          detect_en,
  input logic [CW-4:0] period_out,
  input logic          brk_seen,
  input logic          brk_timeout,
  input logic          sync_timeout,
  input logic          sync_done,
  input logic          rx_ready,
  input logic          txd,
  input logic          tx_busy
);
  // R2 / R3: one low stretch is either a break or a timeout, never both
  p_brk_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(brk_seen && brk_timeout));

  // R5: the period only moves together with a completed measurement
  p_period_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sync_done |-> $stable(period_out));

  // R6: a measurement ends either done or timed out
  p_sync_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(sync_done && sync_timeout));

  // R7: detection off suppresses measurement and timeouts
  p_detect_off_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(detect_en) |-> !sync_done && !brk_timeout && !sync_timeout);

  // R8: ready always has a cause
  p_ready_src_r8: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (sync_done || brk_seen));

  // R11: line idles high outside an emission
  p_tx_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);
endmodule

bind brk_sync_detect brk_sync_detect_sva #(.CW(CW)) u_sva (.*);

// File: tb/brk_sync_detect_test.sv
module brk_sync_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int PW         = CW - 3;
  localparam int BRK_TX     = 13;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          rxd_b, loop_on;
  logic          rxd;
  logic          detect_en, dormant, brk_report_en, tx_brk_req, tx_wr;
  logic [1:0]    delim_sel;
  logic [PW-1:0] base_period;
  logic [7:0]    tx_data;
  logic [PW-1:0] period_out;
  logic          brk_seen, brk_timeout, sync_timeout, sync_done, rx_ready, txd, tx_busy;

  int checks = 0, fails = 0;
  int n_brk = 0, n_bto = 0, n_sto = 0, n_done = 0, n_rdy = 0;
  int s_brk, s_bto, s_sto, s_done, s_rdy;
  int exp_per;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign rxd = loop_on ? txd : rxd_b;

  brk_sync_detect #(.CW(CW), .SYNC_STAGES(2), .TX_BRK_BITS(BRK_TX)) uut (
    .clk(clk), .rst(rst), .rxd(rxd), .detect_en(detect_en), .delim_sel(delim_sel),
    .dormant(dormant), .brk_report_en(brk_report_en), .base_period(base_period),
    .tx_brk_req(tx_brk_req), .tx_wr(tx_wr), .tx_data(tx_data),
    .period_out(period_out), .brk_seen(brk_seen), .brk_timeout(brk_timeout),
    .sync_timeout(sync_timeout), .sync_done(sync_done), .rx_ready(rx_ready),
    .txd(txd), .tx_busy(tx_busy)
  );

  always @(negedge clk) begin
    if (!rst) begin
      n_brk  += int'(brk_seen);
      n_bto  += int'(brk_timeout);
      n_sto  += int'(sync_timeout);
      n_done += int'(sync_done);
      n_rdy  += int'(rx_ready);
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic snap();
    s_brk = n_brk; s_bto = n_bto; s_sto = n_sto; s_done = n_done; s_rdy = n_rdy;
  endtask

  task automatic expect_d(string tag, int brk, int bto, int sto, int done, int rdy, int per);
    chk({tag, " brk_seen"}, n_brk - s_brk, brk);
    chk({tag, " brk_timeout"}, n_bto - s_bto, bto);
    chk({tag, " sync_timeout"}, n_sto - s_sto, sto);
    chk({tag, " sync_done"}, n_done - s_done, done);
    chk({tag, " rx_ready"}, n_rdy - s_rdy, rdy);
    chk({tag, " period"}, int'(period_out), per);
  endtask

  task automatic hold(logic v, int n);
    rxd_b = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_frame(int brk_len, int delim_len, int rate, int extra);
    hold(1'b1, 5);
    hold(1'b0, brk_len);
    hold(1'b1, delim_len);
    hold(1'b0, rate + extra);
    for (int b = 0; b < 8; b++) hold(((8'h55 >> b) & 8'h01) != 0, rate);
    hold(1'b1, rate);
    hold(1'b1, 30);
  endtask

  function automatic logic exp_tx(int k, int dl, logic [7:0] d);
    logic [7:0] sh;
    if (k < BRK_TX) return 1'b0;
    k -= BRK_TX;
    if (k < dl) return 1'b1;
    k -= dl;
    if (k == 0) return 1'b0;
    if (k <= 8) begin
      sh = d >> (k - 1);
      return sh[0];
    end
    return 1'b1;
  endfunction

  task automatic tx_run(string tag, logic auto_md, logic [1:0] d, logic [7:0] data,
                        logic lp, logic mid_wr);
    int dl, len, mid;
    dl  = int'(d) + 1;
    len = BRK_TX + dl + ((auto_md && data == 8'h55) ? 10 : 0);
    mid = (len * exp_per) / 2;
    snap();
    detect_en = auto_md; delim_sel = d; loop_on = lp; tx_data = data;
    tx_brk_req = 1'b1; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    for (int c = 0; c < len * exp_per; c++) begin
      chk({tag, " txd"}, int'(txd), int'(exp_tx(c / exp_per, dl, data)));
      chk({tag, " tx_busy"}, int'(tx_busy), 1);
      tx_wr = (mid_wr && c == mid);
      @(negedge clk);
    end
    tx_wr = 1'b0;
    chk({tag, " txd idle after"}, int'(txd), 1);
    chk({tag, " R11 busy drops"}, int'(tx_busy), 0);
    tx_brk_req = 1'b0;
    repeat (40) @(negedge clk);
    loop_on = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lows[6];
    rst = 1'b1; rxd_b = 1'b1; loop_on = 1'b0;
    detect_en = 1'b0; dormant = 1'b0; brk_report_en = 1'b0;
    delim_sel = 2'd0; base_period = PW'(10);
    tx_brk_req = 1'b0; tx_wr = 1'b0; tx_data = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_per = 10;

    // R1 reset state
    chk("R1 period", int'(period_out), 10);
    chk("R1 txd", int'(txd), 1);
    chk("R1 tx_busy", int'(tx_busy), 0);
    chk("R1 pulses", int'(brk_seen) + int'(brk_timeout) + int'(sync_timeout)
        + int'(sync_done) + int'(rx_ready), 0);

    // R2 / R7: break length sweep, detection off (no timeout even if long)
    lows = '{109, 110, 150, 220, 221, 300};
    foreach (lows[i]) begin
      snap();
      hold(1'b1, 5); hold(1'b0, lows[i]); hold(1'b1, 30);
      expect_d("R2 R7 break sweep", (lows[i] >= 110) ? 1 : 0, 0, 0, 0, 0, 10);
    end

    // R3: break limits with detection on
    detect_en = 1'b1;
    snap(); rx_frame(109, 20, 10, 0); expect_d("R3 short low", 0, 0, 0, 0, 0, 10);
    snap(); rx_frame(220, 20, 10, 0); expect_d("R3 22 bits", 1, 0, 0, 1, 1, 10);
    snap(); rx_frame(221, 20, 10, 0); expect_d("R3 over 22 bits", 0, 1, 0, 0, 0, 10);

    // R4: delimiter codes, one cycle either side of the minimum
    for (int d = 0; d < 4; d++) begin
      for (int ok = 0; ok < 2; ok++) begin
        delim_sel = 2'(d);
        snap();
        rx_frame(150, (d + 1) * 10 - (ok ? 0 : 1), 10, 0);
        expect_d("R4 delimiter", 1, 0, 0, ok, ok, 10);
      end
    end

    // R5 / R8: rate sweep, floor of T/8, ready in dormant mode
    dormant = 1'b1; delim_sel = 2'd3;
    for (int r = 8; r < 32; r++) begin
      for (int e = 0; e < 8; e += 7) begin
        snap();
        rx_frame(15 * exp_per, 4 * exp_per, r, e);
        exp_per = (8 * r + e) / 8;
        expect_d("R5 R8 measure", 1, 0, 0, 1, 1, exp_per);
      end
    end
    dormant = 1'b0;

    // R6: counter span limit
    snap(); rx_frame(15 * exp_per, 4 * exp_per, 32, 0);
    expect_d("R6 T=256 timeout", 1, 0, 1, 0, 0, exp_per);
    snap(); rx_frame(15 * exp_per, 4 * exp_per, 16, 0); exp_per = 16;
    expect_d("R5 rate 16", 1, 0, 0, 1, 1, 16);
    snap(); rx_frame(15 * exp_per, 4 * exp_per, 31, 7); exp_per = 31;
    expect_d("R6 T=255 accepted", 1, 0, 0, 1, 1, 31);

    // R7: detection off keeps the period and never times out
    detect_en = 1'b0;
    snap(); rx_frame(15 * exp_per, 4 * exp_per, 12, 0);
    expect_d("R7 frame ignored", 1, 0, 0, 0, 0, 31);
    snap(); hold(1'b1, 5); hold(1'b0, 30 * exp_per); hold(1'b1, 30);
    expect_d("R7 long low", 1, 0, 0, 0, 0, 31);

    // R8: break reporting versus dormant
    for (int rep = 0; rep < 2; rep++) begin
      for (int dm = 0; dm < 2; dm++) begin
        brk_report_en = rep[0]; dormant = dm[0];
        snap(); hold(1'b1, 5); hold(1'b0, 15 * exp_per); hold(1'b1, 30);
        expect_d("R8 break ready", 1, 0, 0, 0, (rep == 1 && dm == 0) ? 1 : 0, 31);
      end
    end
    brk_report_en = 1'b0; dormant = 1'b0;

    // R9: full break + delimiter + synch, looped back into the receiver
    tx_run("R9 auto synch", 1'b1, 2'd2, 8'h55, 1'b1, 1'b0);
    expect_d("R9 loopback", 1, 0, 0, 1, 1, 31);

    // R10: break only, and writes that must be ignored
    tx_run("R10 non-auto", 1'b0, 2'd1, 8'h55, 1'b0, 1'b1);
    tx_run("R10 data zero", 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    tx_data = 8'h55; detect_en = 1'b1; tx_brk_req = 1'b0; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    for (int c = 0; c < 20; c++) begin
      chk("R10 plain write txd", int'(txd), 1);
      chk("R10 plain write busy", int'(tx_busy), 0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule